// File: doc/BRIEF.md
# I2C Master Clock Phase Timer

This block times the clock line for an I2C master running from a 40 MHz reference, where one reference cycle is 25 ns. It supports three speed classes. Standard speed uses a 100 kb/s ceiling and a 400-cycle nominal period. Fast speed uses 400 kb/s and 100 cycles. Fast-plus speed uses 1000 kb/s and 40 cycles.

Software gives the bus rise time in nanoseconds. The block rounds this value to whole reference cycles and removes it from the nominal period. What remains is split into a driven-low phase and a released phase. The time the line spends rising therefore does not lengthen the period seen on the bus.

The block drives the line low for the low phase. It then releases the line and waits until it samples the line high. Only then does it start counting the high phase, so a slave that holds the clock low simply stretches the period. Two single-cycle strobes mark the middle of each phase. The mid-low strobe tells the data path when to change SDA. The mid-high strobe tells it when to sample SDA.

Top module: `scl_timer`

## Requirements
- R1: `speed_mode` picks the nominal period. Code 0 gives 400 cycles, code 1 gives 100 cycles, and codes 2 and 3 both give 40 cycles.
- R2: The rise setting `rise_ns` is converted to reference cycles as floor((rise_ns + 12) / 25), which rounds to the nearest 25 ns. For example, 33 ns gives 1 cycle and 38 ns gives 2 cycles.
- R3: The available count is the nominal period minus the rise cycles. The high count is floor(2 × available / 5), but never less than 4. The low count is the available count minus the high count, so the low phase is never the shorter one.
- R4: If the rise cycles exceed the nominal period minus 8, the available count is clamped to 8. Both phases then last 4 cycles.
- R5: During each period, `scl_drive_low` is high for exactly the low count of consecutive cycles.
- R6: High-phase counting starts in the first cycle the line is sampled high. With an ideal bus, the line stays released for exactly the high count. Each cycle a slave holds the line low adds one cycle to the released interval.
- R7: `mid_low_stb` is a one-cycle pulse, issued once per low phase. It comes floor(low/2) cycles after `scl_drive_low` rises.
- R8: `mid_high_stb` is a one-cycle pulse, issued once per released phase. It comes floor(high/2) cycles plus any stretch cycles after `scl_drive_low` falls.
- R9: In idle, an asserted `en` makes `scl_drive_low` rise at the next clock edge. A new low phase can only start while `en` is high. When `en` drops, the current period runs to its end. After that the line stays released and no strobes are issued.
- R10: The phase counts are captured when each low phase starts. A change to `speed_mode` or `rise_ns` part way through a period takes effect only from the next period.
- R11: While `rst` is high and right after it is released, `scl_drive_low`, `mid_low_stb` and `mid_high_stb` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run clock periods while high |
| speed_mode | input | 2 | 0 standard, 1 fast, 2 or 3 fast-plus |
| rise_ns | input | 12 | Bus rise-time allowance in nanoseconds |
| scl_in | input | 1 | Sampled level of the clock line |
| scl_drive_low | output | 1 | Pull the clock line low when 1 |
| mid_low_stb | output | 1 | Single-cycle pulse in the middle of the low phase |
| mid_high_stb | output | 1 | Single-cycle pulse in the middle of the high phase |

## Verification
The hardest case to reach from the ports is a settings change that lands inside a running period. The counts for the next period come through a register stage, while the current period must keep the counts it captured when it started. The bench handles this with a forked process. It changes `speed_mode` and `rise_ns` two cycles into a fast-speed low phase, then measures both that period and the one after it.

Clock stretching is the second hard case. The bench models the line as released only when the block stops driving it and a hold flag is clear. It sets the hold flag in the half cycle after the release and keeps it set for a chosen number of edges. This moves the high phase and the mid-high strobe later by exactly that number of cycles.

// File: rtl/scl_timer_pkg.sv
package scl_timer_pkg;

  typedef enum logic [1:0] {
    SPD_STD   = 2'd0,
    SPD_FAST  = 2'd1,
    SPD_FPLUS = 2'd2,
    SPD_FPALT = 2'd3
  } speed_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_HIGH = 2'd3
  } phase_e;

endpackage

// File: rtl/scl_phase_calc.sv
module scl_phase_calc
  import scl_timer_pkg::*;
#(
  parameter int REF_NS    = 25,
  parameter int STD_CYC   = 400,
  parameter int FAST_CYC  = 100,
  parameter int FPLUS_CYC = 40,
  parameter int MIN_PHASE = 4,
  parameter int HIGH_NUM  = 2,
  parameter int HIGH_DEN  = 5,
  parameter int RISE_W    = 12,
  parameter int CNT_W     = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        speed,
  input  logic [RISE_W-1:0] rise_ns,
  output logic [CNT_W-1:0]  low_cyc,
  output logic [CNT_W-1:0]  high_cyc
);

  localparam int WW       = (RISE_W + 1 > CNT_W + 2) ? RISE_W + 1 : CNT_W + 2;
  localparam int HALF_REF = REF_NS / 2;
  localparam int FLOOR_AV = 2 * MIN_PHASE;

  logic [WW-1:0] nominal, rise_cyc, avail, hi_v, lo_v;

  always_comb begin
    case (speed_e'(speed))
      SPD_STD:  nominal = WW'(STD_CYC);
      SPD_FAST: nominal = WW'(FAST_CYC);
      default:  nominal = WW'(FPLUS_CYC);
    endcase
    rise_cyc = (WW'(rise_ns) + WW'(HALF_REF)) / WW'(REF_NS);
    if (rise_cyc + WW'(FLOOR_AV) > nominal) avail = WW'(FLOOR_AV);
    else                                     avail = nominal - rise_cyc;
    hi_v = (avail * WW'(HIGH_NUM)) / WW'(HIGH_DEN);
    if (hi_v < WW'(MIN_PHASE)) hi_v = WW'(MIN_PHASE);
    lo_v = avail - hi_v;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cyc  <= CNT_W'(MIN_PHASE);
      high_cyc <= CNT_W'(MIN_PHASE);
    end else begin
      low_cyc  <= CNT_W'(lo_v);
      high_cyc <= CNT_W'(hi_v);
    end
  end

  p_min_phase_r4: assert property (@(posedge clk) disable iff (rst)
    (low_cyc >= CNT_W'(MIN_PHASE)) && (high_cyc >= CNT_W'(MIN_PHASE)));

  p_low_share_r3: assert property (@(posedge clk) disable iff (rst)
    low_cyc >= high_cyc);

endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq
  import scl_timer_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             scl_in,
  input  logic [CNT_W-1:0] low_cyc,
  input  logic [CNT_W-1:0] high_cyc,
  output logic             drive_low,
  output logic             mid_low,
  output logic             mid_high
);

  phase_e           state;
  logic [CNT_W-1:0] cnt, lo_lat, hi_lat;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= PH_IDLE;
      cnt       <= '0;
      lo_lat    <= '0;
      hi_lat    <= '0;
      drive_low <= 1'b0;
      mid_low   <= 1'b0;
      mid_high  <= 1'b0;
    end else begin
      mid_low  <= 1'b0;
      mid_high <= 1'b0;
      case (state)
        PH_IDLE: begin
          if (en) begin
            state     <= PH_LOW;
            cnt       <= '0;
            lo_lat    <= low_cyc;
            hi_lat    <= high_cyc;
            drive_low <= 1'b1;
          end
        end
        PH_LOW: begin
          cnt <= cnt + CNT_W'(1);
          if (cnt == (lo_lat >> 1) - CNT_W'(1)) mid_low <= 1'b1;
          if (cnt == lo_lat - CNT_W'(1)) begin
            state     <= PH_WAIT;
            drive_low <= 1'b0;
          end
        end
        PH_WAIT: begin
          if (scl_in) begin
            state <= PH_HIGH;
            cnt   <= CNT_W'(1);
          end
        end
        PH_HIGH: begin
          cnt <= cnt + CNT_W'(1);
          if (cnt == (hi_lat >> 1) - CNT_W'(1)) mid_high <= 1'b1;
          if (cnt == hi_lat - CNT_W'(1)) begin
            if (en) begin
              state     <= PH_LOW;
              cnt       <= '0;
              lo_lat    <= low_cyc;
              hi_lat    <= high_cyc;
              drive_low <= 1'b1;
            end else begin
              state <= PH_IDLE;
            end
          end
        end
        default: state <= PH_IDLE;
      endcase
    end
  end

  p_mid_low_in_low_r7: assert property (@(posedge clk) disable iff (rst)
    mid_low |-> drive_low);

  p_mid_low_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    mid_low |=> !mid_low);

  p_mid_high_released_r8: assert property (@(posedge clk) disable iff (rst)
    mid_high |-> !drive_low);

  p_mid_high_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    mid_high |=> !mid_high);

  p_start_needs_en_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(drive_low) |-> $past(en));

  p_stretch_holds_r6: assert property (@(posedge clk) disable iff (rst)
    (state == PH_WAIT && !scl_in) |=> !drive_low);

endmodule

// File: rtl/scl_timer.sv
module scl_timer #(
  parameter int REF_NS    = 25,
  parameter int STD_CYC   = 400,
  parameter int FAST_CYC  = 100,
  parameter int FPLUS_CYC = 40,
  parameter int MIN_PHASE = 4,
  parameter int RISE_W    = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [1:0]        speed_mode,
  input  logic [RISE_W-1:0] rise_ns,
  input  logic              scl_in,
  output logic              scl_drive_low,
  output logic              mid_low_stb,
  output logic              mid_high_stb
);

  localparam int CNT_W = $clog2(STD_CYC + 1);

  logic [CNT_W-1:0] low_cyc, high_cyc;

  scl_phase_calc #(
    .REF_NS(REF_NS), .STD_CYC(STD_CYC), .FAST_CYC(FAST_CYC),
    .FPLUS_CYC(FPLUS_CYC), .MIN_PHASE(MIN_PHASE), .HIGH_NUM(2),
    .HIGH_DEN(5), .RISE_W(RISE_W), .CNT_W(CNT_W)
  ) u_calc (
    .clk(clk), .rst(rst), .speed(speed_mode), .rise_ns(rise_ns),
    .low_cyc(low_cyc), .high_cyc(high_cyc)
  );

  scl_phase_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .en(en), .scl_in(scl_in),
    .low_cyc(low_cyc), .high_cyc(high_cyc),
    .drive_low(scl_drive_low), .mid_low(mid_low_stb), .mid_high(mid_high_stb)
  );

endmodule

// File: tb/scl_timer_bench.sv
module scl_timer_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [1:0]  speed_mode = 2'd0;
  logic [11:0] rise_ns = 12'd50;
  logic        hold = 1'b0;
  logic        scl_in;
  logic        scl_drive_low, mid_low_stb, mid_high_stb;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  assign scl_in = ~scl_drive_low & ~hold;

  scl_timer u_scl_timer (
    .clk(clk), .rst(rst), .en(en), .speed_mode(speed_mode), .rise_ns(rise_ns),
    .scl_in(scl_in), .scl_drive_low(scl_drive_low),
    .mid_low_stb(mid_low_stb), .mid_high_stb(mid_high_stb)
  );

  typedef struct packed {
    logic [1:0]  spd;
    logic [11:0] rise;
    logic [7:0]  str;
    logic [8:0]  lo;
    logic [8:0]  hi;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 12'd50,   8'd0, 9'd239, 9'd159},
    '{2'd1, 12'd100,  8'd0, 9'd58,  9'd38},
    '{2'd2, 12'd50,   8'd0, 9'd23,  9'd15},
    '{2'd1, 12'd0,    8'd0, 9'd60,  9'd40},
    '{2'd1, 12'd33,   8'd0, 9'd60,  9'd39},
    '{2'd1, 12'd38,   8'd0, 9'd59,  9'd39},
    '{2'd1, 12'd2500, 8'd0, 9'd4,   9'd4},
    '{2'd2, 12'd750,  8'd0, 9'd6,   9'd4},
    '{2'd2, 12'd1000, 8'd0, 9'd4,   9'd4},
    '{2'd0, 12'd4000, 8'd0, 9'd144, 9'd96},
    '{2'd1, 12'd100,  8'd7, 9'd58,  9'd38},
    '{2'd3, 12'd50,   8'd0, 9'd23,  9'd15}
  };

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic measure(input int stretch,
                         output int lo_len, output int lo_idx, output int lo_n,
                         output int hi_len, output int hi_idx, output int hi_n);
    int idx;
    lo_len = 0; lo_idx = -1; lo_n = 0;
    hi_len = 0; hi_idx = -1; hi_n = 0;
    while (!scl_drive_low) @(negedge clk);
    idx = 0;
    while (scl_drive_low) begin
      if (mid_low_stb) begin lo_n++; lo_idx = idx; end
      lo_len++; idx++;
      @(negedge clk);
    end
    idx = 0;
    if (stretch > 0) hold = 1'b1;
    while (!scl_drive_low) begin
      if (mid_high_stb) begin hi_n++; hi_idx = idx; end
      hi_len++; idx++;
      if (idx > stretch) hold = 1'b0;
      @(negedge clk);
    end
    hold = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int ll, li, ln, hl, hi, hn, idle_bad;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!scl_drive_low && !mid_low_stb && !mid_high_stb, "R11 outputs in reset",
        {29'd0, scl_drive_low, mid_low_stb, mid_high_stb}, 0);
    rst = 1'b0;
    idle_bad = 0;
    repeat (20) begin
      @(negedge clk);
      if (scl_drive_low || mid_low_stb || mid_high_stb) idle_bad++;
    end
    chk(idle_bad == 0, "R11 R9 idle after reset with en low", idle_bad, 0);

    // table of vectors: R1 R2 R3 R4 R5 R6 R7 R8
    for (int v = 0; v < NV; v++) begin
      speed_mode = VECS[v].spd;
      rise_ns    = VECS[v].rise;
      repeat (4) @(negedge clk);
      en = 1'b1;
      measure(int'(VECS[v].str), ll, li, ln, hl, hi, hn);
      chk(ll == int'(VECS[v].lo), $sformatf("R5 low length (R1 R2 R3 R4) row %0d", v), ll, int'(VECS[v].lo));
      chk(hl == int'(VECS[v].hi) + int'(VECS[v].str),
          $sformatf("R6 released length (R3 R4) row %0d", v), hl, int'(VECS[v].hi) + int'(VECS[v].str));
      chk(ln == 1 && li == int'(VECS[v].lo) / 2, $sformatf("R7 mid-low position row %0d", v),
          li, int'(VECS[v].lo) / 2);
      chk(hn == 1 && hi == int'(VECS[v].hi) / 2 + int'(VECS[v].str),
          $sformatf("R8 mid-high position row %0d", v), hi, int'(VECS[v].hi) / 2 + int'(VECS[v].str));
      en = 1'b0;
      repeat (900) @(negedge clk);
    end

    // R10: settings changed inside a running period
    speed_mode = 2'd1; rise_ns = 12'd100;
    repeat (4) @(negedge clk);
    en = 1'b1;
    fork
      measure(0, ll, li, ln, hl, hi, hn);
      begin
        @(negedge clk); @(negedge clk);
        speed_mode = 2'd2; rise_ns = 12'd50;
      end
    join
    chk(ll == 58, "R10 current low keeps old count", ll, 58);
    chk(hl == 38, "R10 current high keeps old count", hl, 38);
    measure(0, ll, li, ln, hl, hi, hn);
    chk(ll == 23, "R10 next low uses new count", ll, 23);
    chk(hl == 15, "R10 next high uses new count", hl, 15);

    // R9: dropping enable finishes the period then stays released
    ll = 0;
    en = 1'b0;
    while (scl_drive_low) begin ll++; @(negedge clk); end
    chk(ll >= 22, "R9 low phase runs to its end after disable", ll, 22);
    repeat (20) @(negedge clk);
    idle_bad = 0;
    repeat (300) begin
      @(negedge clk);
      if (scl_drive_low || mid_low_stb || mid_high_stb) idle_bad++;
    end
    chk(idle_bad == 0, "R9 released and silent after disable", idle_bad, 0);

    // R9: start is one edge after enable in idle
    en = 1'b1;
    @(negedge clk);
    chk(scl_drive_low, "R9 low starts one edge after enable", int'(scl_drive_low), 1);
    en = 1'b0;
    repeat (100) @(negedge clk);

    summary();
    $finish;
  end

endmodule